// File: doc/BRIEF.md
# Flash Program/Erase Sequencing Controller

This controller carries out the word-program and block-erase algorithms of a NOR-style nonvolatile array. The host issues a single command (program one word, erase the block holding an address, or clear the error flags) and then polls a status word until the ready flag returns. The pulse timing, the pulse counting, the read-back verify and the pre-programming before an erase all run inside the block, with no further involvement from the host.

The array side is a behavioural cell model. The controller drives an address, a write data word, a program strobe and an erase strobe, and it reads the addressed word back combinationally. Blocks in the array are not all the same size. A boot block sits at address zero, two small parameter blocks follow it, and uniform main blocks fill the rest of the space. Each block size is a parameter given as a power of two. The boot block accepts a program or erase command only when at least one of two unlock inputs is high while the command is taken.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset, status reads 4'b0001 (bit 0 ready=1; bit 1 program error, bit 2 erase error and bit 3 protection error all 0), and neither strobe is active.
- R2: A program command (cmd_op=2'b01) drives the command address and data to the array. Each program strobe lasts exactly PGM_PULSE_CYC cycles. After each strobe the word is read back, and strobes repeat until the read-back equals the data; then ready returns.
- R3: If the word still mismatches after exactly MAX_PGM_PULSES strobes, the controller stops, sets status bit 1 and returns to ready.
- R4: An erase command (cmd_op=2'b10) first programs every word of the target block to zero, in ascending address order starting at the block base, before the first erase strobe.
- R5: Each erase strobe lasts exactly ERS_PULSE_CYC cycles. After each strobe the words are checked for all ones in ascending order. The next strobe is issued with the first failing address on the array address port, and the erase ends once the last word of the block passes.
- R6: If the block is still not all ones after MAX_ERS_PULSES erase strobes, the controller sets status bit 2 and returns to ready.
- R7: Block map: words [0, 2^BOOT_LG) form the boot block, two blocks of 2^PARAM_LG words follow, and main blocks of 2^MAIN_LG words follow those (the last one is clipped at the top of the space). An erase touches exactly the block that holds the command address.
- R8: A program or erase command aimed at the boot block, with both boot_unlock_hv and boot_unlock_wp low, is rejected: no strobe is issued, status bit 3 is set and ready stays 1. With either unlock input high, the command runs normally.
- R9: Status bit 0 is 0 for the whole of an operation. Commands presented while it is 0 are ignored.
- R10: Error bits are sticky across later successful operations. A clear command (cmd_op=2'b11) accepted while ready sets bits 1 to 3 to zero.
- R11: The program and erase strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken while ready |
| cmd_op | input | 2 | 01 program, 10 block erase, 11 clear errors, 00 none |
| cmd_addr | input | AW | Word address (any word of the block for an erase) |
| cmd_data | input | DW | Word to program |
| boot_unlock_hv | input | 1 | Boot block unlock (high-voltage style override) |
| boot_unlock_wp | input | 1 | Boot block unlock (write-protect release) |
| status | output | 4 | {prot_err, erase_err, prog_err, ready} |
| arr_addr | output | AW | Array word address |
| arr_wdata | output | DW | Array program data |
| arr_pgm_pulse | output | 1 | Program strobe |
| arr_ers_pulse | output | 1 | Erase strobe |
| arr_rdata | input | DW | Array read-back of arr_addr |

## Verification
The bench builds the block with a 128-word, 8-bit space: a 16-word boot block, two 8-word parameter blocks and three 32-word main blocks. It uses 3-cycle program strobes, 5-cycle erase strobes and pulse limits of 6 and 4. With these values every block boundary can be probed next to its neighbours, a whole block can be pre-programmed in a few hundred cycles, and both pulse limits are reached by cells in the model that resist programming or erasure. The array model also needs several strobes for selected words, so the retry loops and the resume-from-failing-address behaviour appear at the ports.

// File: rtl/fsc_pkg.sv
// Shared command encodings, sequencer states and status bit positions for
// the flash program/erase sequencer. Assumes a two-bit command field.
package fsc_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_CLR   = 2'b11
    } fsc_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PPULSE,
        S_PVERIFY,
        S_EPULSE,
        S_EVERIFY
    } fsc_state_e;

    localparam int ST_READY = 0;
    localparam int ST_PERR  = 1;
    localparam int ST_EERR  = 2;
    localparam int ST_PROT  = 3;

endpackage

// File: rtl/fsc_blkmap.sv
// Block map decoder: turns a word address into the first and last word of
// its erase block and flags the boot block. Assumes the boot block at word
// zero, two parameter blocks after it, then uniform main blocks; the last
// main block is clipped at the top of the address space.
module fsc_blkmap #(
    parameter int AW       = 18,
    parameter int BOOT_LG  = 13,
    parameter int PARAM_LG = 12,
    parameter int MAIN_LG  = 16
) (
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] blk_base,
    output logic [AW-1:0] blk_last,
    output logic          blk_boot
);
    localparam int XW = AW + 2;
    localparam logic [XW-1:0] BOOT_W    = XW'(1) << BOOT_LG;
    localparam logic [XW-1:0] PARAM_W   = XW'(1) << PARAM_LG;
    localparam logic [XW-1:0] MAIN_W    = XW'(1) << MAIN_LG;
    localparam logic [XW-1:0] PARAM_END = BOOT_W + (PARAM_W << 1);
    localparam logic [XW-1:0] TOP       = (XW'(1) << AW) - XW'(1);

    logic [XW-1:0] a_x, off_x, base_x, last_x;

    // Region compare, aligned base and clipped end for the address.
    always_comb begin
        a_x      = {2'b00, addr};
        off_x    = '0;
        blk_boot = 1'b0;
        if (a_x < BOOT_W) begin
            base_x   = '0;
            last_x   = BOOT_W - XW'(1);
            blk_boot = 1'b1;
        end else if (a_x < PARAM_END) begin
            off_x  = a_x - BOOT_W;
            base_x = BOOT_W + ((off_x >> PARAM_LG) << PARAM_LG);
            last_x = base_x + PARAM_W - XW'(1);
        end else begin
            off_x  = a_x - PARAM_END;
            base_x = PARAM_END + ((off_x >> MAIN_LG) << MAIN_LG);
            last_x = base_x + MAIN_W - XW'(1);
        end
        if (last_x > TOP) begin
            last_x = TOP;
        end
        blk_base = base_x[AW-1:0];
        blk_last = last_x[AW-1:0];
    end

endmodule

// File: rtl/fsc_pulse_timer.sv
// Strobe length timer: counts cycles while run is high and flags the last
// cycle of a strobe of len cycles. Assumes len >= 1 and that run drops for
// at least one cycle between strobes.
module fsc_pulse_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] len,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    // Count strobe cycles, restart from zero whenever run is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    assign done = run && (cnt_q == len - TW'(1));

endmodule

// File: rtl/fsc_seq.sv
// Program/erase sequencer: accepts host commands while idle, checks boot
// protection, then runs strobe/verify loops. Erase pre-programs the block
// to zero, then pulses and verifies, resuming at the first failing word.
// Assumes arr_rdata reflects arr_addr in the same cycle.
module fsc_seq
    import fsc_pkg::*;
#(
    parameter int AW             = 18,
    parameter int DW             = 16,
    parameter int PGM_PULSE_CYC  = 8,
    parameter int ERS_PULSE_CYC  = 64,
    parameter int MAX_PGM_PULSES = 25,
    parameter int MAX_ERS_PULSES = 1000,
    parameter int TW             = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          unlock,
    input  logic [AW-1:0] map_base,
    input  logic [AW-1:0] map_last,
    input  logic          map_boot,
    input  logic          tmr_done,
    output logic          tmr_run,
    output logic [TW-1:0] tmr_len,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          arr_pgm_pulse,
    output logic          arr_ers_pulse,
    input  logic [DW-1:0] arr_rdata,
    output logic [3:0]    status
);
    localparam int PW = $clog2(MAX_PGM_PULSES + 1);
    localparam int EW = $clog2(MAX_ERS_PULSES + 1);

    fsc_state_e    state_q;
    fsc_op_e       op;
    logic          erasing_q;
    logic [AW-1:0] addr_q, base_q, last_q;
    logic [DW-1:0] data_q;
    logic [PW-1:0] pcnt_q;
    logic [EW-1:0] ecnt_q;
    logic          perr_q, eerr_q, prot_q;
    logic          blocked;

    assign op      = fsc_op_e'(cmd_op);
    assign blocked = map_boot && !unlock;

    // Command intake, strobe/verify loops and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            erasing_q <= 1'b0;
            addr_q    <= '0;
            base_q    <= '0;
            last_q    <= '0;
            data_q    <= '0;
            pcnt_q    <= '0;
            ecnt_q    <= '0;
            perr_q    <= 1'b0;
            eerr_q    <= 1'b0;
            prot_q    <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        case (op)
                            OP_CLR: begin
                                perr_q <= 1'b0;
                                eerr_q <= 1'b0;
                                prot_q <= 1'b0;
                            end
                            OP_PROG: begin
                                if (blocked) begin
                                    prot_q <= 1'b1;
                                end else begin
                                    addr_q    <= cmd_addr;
                                    data_q    <= cmd_data;
                                    erasing_q <= 1'b0;
                                    pcnt_q    <= '0;
                                    state_q   <= S_PPULSE;
                                end
                            end
                            OP_ERASE: begin
                                if (blocked) begin
                                    prot_q <= 1'b1;
                                end else begin
                                    addr_q    <= map_base;
                                    base_q    <= map_base;
                                    last_q    <= map_last;
                                    data_q    <= '0;
                                    erasing_q <= 1'b1;
                                    pcnt_q    <= '0;
                                    ecnt_q    <= '0;
                                    state_q   <= S_PPULSE;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                S_PPULSE: begin
                    if (tmr_done) begin
                        pcnt_q  <= pcnt_q + PW'(1);
                        state_q <= S_PVERIFY;
                    end
                end
                S_PVERIFY: begin
                    if (arr_rdata == data_q) begin
                        if (!erasing_q) begin
                            state_q <= S_IDLE;
                        end else if (addr_q == last_q) begin
                            addr_q  <= base_q;
                            state_q <= S_EPULSE;
                        end else begin
                            addr_q  <= addr_q + AW'(1);
                            pcnt_q  <= '0;
                            state_q <= S_PPULSE;
                        end
                    end else if (pcnt_q == PW'(MAX_PGM_PULSES)) begin
                        if (erasing_q) begin
                            eerr_q <= 1'b1;
                        end else begin
                            perr_q <= 1'b1;
                        end
                        state_q <= S_IDLE;
                    end else begin
                        state_q <= S_PPULSE;
                    end
                end
                S_EPULSE: begin
                    if (tmr_done) begin
                        ecnt_q  <= ecnt_q + EW'(1);
                        state_q <= S_EVERIFY;
                    end
                end
                S_EVERIFY: begin
                    if (&arr_rdata) begin
                        if (addr_q == last_q) begin
                            state_q <= S_IDLE;
                        end else begin
                            addr_q <= addr_q + AW'(1);
                        end
                    end else if (ecnt_q == EW'(MAX_ERS_PULSES)) begin
                        eerr_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        state_q <= S_EPULSE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Strobes, timer control and status word from the sequencer state.
    always_comb begin
        arr_pgm_pulse = (state_q == S_PPULSE);
        arr_ers_pulse = (state_q == S_EPULSE);
        tmr_run       = arr_pgm_pulse || arr_ers_pulse;
        tmr_len       = arr_ers_pulse ? TW'(ERS_PULSE_CYC) : TW'(PGM_PULSE_CYC);
        arr_addr      = addr_q;
        arr_wdata     = data_q;
        status        = '0;
        status[ST_READY] = (state_q == S_IDLE);
        status[ST_PERR]  = perr_q;
        status[ST_EERR]  = eerr_q;
        status[ST_PROT]  = prot_q;
    end

endmodule

// File: rtl/flash_pe_seq.sv
// Top of the flash program/erase sequencing controller. Joins the block map
// decoder, the strobe timer and the sequencer. Assumes a combinational
// array read path and host polling of the status word.
module flash_pe_seq #(
    parameter int AW             = 18,
    parameter int DW             = 16,
    parameter int BOOT_LG        = 13,
    parameter int PARAM_LG       = 12,
    parameter int MAIN_LG        = 16,
    parameter int PGM_PULSE_CYC  = 8,
    parameter int ERS_PULSE_CYC  = 64,
    parameter int MAX_PGM_PULSES = 25,
    parameter int MAX_ERS_PULSES = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          boot_unlock_hv,
    input  logic          boot_unlock_wp,
    output logic [3:0]    status,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          arr_pgm_pulse,
    output logic          arr_ers_pulse,
    input  logic [DW-1:0] arr_rdata
);
    localparam int LONGEST = (PGM_PULSE_CYC > ERS_PULSE_CYC) ? PGM_PULSE_CYC : ERS_PULSE_CYC;
    localparam int TW      = $clog2(LONGEST + 1);

    logic [AW-1:0] map_base, map_last;
    logic          map_boot;
    logic          tmr_run, tmr_done;
    logic [TW-1:0] tmr_len;

    fsc_blkmap #(
        .AW(AW), .BOOT_LG(BOOT_LG), .PARAM_LG(PARAM_LG), .MAIN_LG(MAIN_LG)
    ) u_map (
        .addr(cmd_addr), .blk_base(map_base), .blk_last(map_last), .blk_boot(map_boot)
    );

    fsc_pulse_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .len(tmr_len), .done(tmr_done)
    );

    fsc_seq #(
        .AW(AW), .DW(DW), .PGM_PULSE_CYC(PGM_PULSE_CYC), .ERS_PULSE_CYC(ERS_PULSE_CYC),
        .MAX_PGM_PULSES(MAX_PGM_PULSES), .MAX_ERS_PULSES(MAX_ERS_PULSES), .TW(TW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .unlock(boot_unlock_hv || boot_unlock_wp),
        .map_base(map_base), .map_last(map_last), .map_boot(map_boot),
        .tmr_done(tmr_done), .tmr_run(tmr_run), .tmr_len(tmr_len),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_pgm_pulse(arr_pgm_pulse), .arr_ers_pulse(arr_ers_pulse),
        .arr_rdata(arr_rdata), .status(status)
    );

endmodule

// File: rtl/flash_pe_seq_chk.sv
// Property checker for flash_pe_seq, attached by bind. Watches only the top
// ports; strobe widths are measured with local counters.
module flash_pe_seq_chk #(
    parameter int AW            = 18,
    parameter int BOOT_LG       = 13,
    parameter int PGM_PULSE_CYC = 8,
    parameter int ERS_PULSE_CYC = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic [AW-1:0] cmd_addr,
    input logic          boot_unlock_hv,
    input logic          boot_unlock_wp,
    input logic [3:0]    status,
    input logic          arr_pgm_pulse,
    input logic          arr_ers_pulse
);
    localparam logic [AW:0] BOOT_W = (AW + 1)'(1) << BOOT_LG;

    int  pw_q, ew_q;
    logic take, boot_cmd, clr_cmd;

    assign take     = status[0] && cmd_valid;
    assign boot_cmd = take && (cmd_op == 2'b01 || cmd_op == 2'b10)
                      && ({1'b0, cmd_addr} < BOOT_W) && !boot_unlock_hv && !boot_unlock_wp;
    assign clr_cmd  = take && (cmd_op == 2'b11);

    // Count consecutive high cycles of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_q <= 0;
            ew_q <= 0;
        end else begin
            pw_q <= arr_pgm_pulse ? pw_q + 1 : 0;
            ew_q <= arr_ers_pulse ? ew_q + 1 : 0;
        end
    end

    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_pgm_pulse && arr_ers_pulse));
    a_r2_pgm_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_pgm_pulse) |-> (pw_q == PGM_PULSE_CYC));
    a_r5_ers_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_ers_pulse) |-> (ew_q == ERS_PULSE_CYC));
    a_r8_boot_reject: assert property (@(posedge clk) disable iff (!rst_n)
        boot_cmd |=> (status[3] && status[0] && !arr_pgm_pulse && !arr_ers_pulse));
    a_r9_busy_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_pgm_pulse || arr_ers_pulse) |-> !status[0]);
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (status[3:1] == 3'b000));
    a_r10_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !clr_cmd) |=> status[1]);
    a_r10_eerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !clr_cmd) |=> status[2]);

endmodule

bind flash_pe_seq flash_pe_seq_chk #(
    .AW(AW), .BOOT_LG(BOOT_LG), .PGM_PULSE_CYC(PGM_PULSE_CYC), .ERS_PULSE_CYC(ERS_PULSE_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .boot_unlock_hv(boot_unlock_hv), .boot_unlock_wp(boot_unlock_wp), .status(status),
    .arr_pgm_pulse(arr_pgm_pulse), .arr_ers_pulse(arr_ers_pulse)
);

// File: tb/flash_pe_seq_tb.sv
`timescale 1ns/1ps
module flash_pe_seq_tb;
    localparam int AW = 7, DW = 8, NW = 128;
    localparam int PGM_CYC = 3, ERS_CYC = 5, MAXP = 6, MAXE = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic hv = 1'b0, wp = 1'b0;
    logic [3:0] status;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata, arr_rdata;
    logic pgm, ers;

    always #2 clk = ~clk;

    flash_pe_seq #(
        .AW(AW), .DW(DW), .BOOT_LG(4), .PARAM_LG(3), .MAIN_LG(5),
        .PGM_PULSE_CYC(PGM_CYC), .ERS_PULSE_CYC(ERS_CYC),
        .MAX_PGM_PULSES(MAXP), .MAX_ERS_PULSES(MAXE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .boot_unlock_hv(hv),
        .boot_unlock_wp(wp), .status(status), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_pgm_pulse(pgm), .arr_ers_pulse(ers),
        .arr_rdata(arr_rdata)
    );

    // Behavioural cell array
    logic [DW-1:0] mem [NW];
    int pc [NW];
    int ec [NW];
    int ers_need [NW];
    int pgm_need = 1;
    int pgm_log [64];
    int ers_log [64];
    int pgm_n = 0, ers_n = 0;
    int n_chk = 0, n_err = 0;
    int pwc = 0, ewc = 0;
    logic pp = 1'b0, ep = 1'b0;
    bit done_flag = 0;

    assign arr_rdata = mem[arr_addr];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int blk_lo(input int a);
        if (a < 16) return 0;
        if (a < 24) return 16;
        if (a < 32) return 24;
        return 32 + ((a - 32) / 32) * 32;
    endfunction

    function automatic int blk_hi(input int a);
        if (a < 16) return 15;
        if (a < 24) return 23;
        if (a < 32) return 31;
        return blk_lo(a) + 31;
    endfunction

    // Array model reaction, strobe logging and strobe width checks
    always @(posedge clk) begin
        if (pgm && !pp) begin
            if (pgm_n < 64) pgm_log[pgm_n] = int'(arr_addr);
            pgm_n++;
            pc[arr_addr]++;
            if (pc[arr_addr] >= pgm_need) mem[arr_addr] = mem[arr_addr] & arr_wdata;
        end
        if (ers && !ep) begin
            if (ers_n < 64) ers_log[ers_n] = int'(arr_addr);
            ers_n++;
            for (int i = blk_lo(int'(arr_addr)); i <= blk_hi(int'(arr_addr)); i++) begin
                ec[i]++;
                if (ec[i] >= ers_need[i]) mem[i] = '1;
            end
        end
        if (pgm && ers) chk("R11", "strobe overlap", 1, 0);
        if (!pgm && pp) chk("R2", "program strobe width", pwc, PGM_CYC);
        if (!ers && ep) chk("R5", "erase strobe width", ewc, ERS_CYC);
        pwc = pgm ? pwc + 1 : 0;
        ewc = ers ? ewc + 1 : 0;
        pp = pgm;
        ep = ers;
    end

    task automatic clear_logs();
        pgm_n = 0;
        ers_n = 0;
        for (int i = 0; i < NW; i++) begin
            pc[i] = 0;
            ec[i] = 0;
        end
    endtask

    task automatic issue(input logic [1:0] op, input int a, input int d, input logic h, input logic w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_addr = AW'(a);
        cmd_data = DW'(d);
        hv = h;
        wp = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 2'b00;
    endtask

    task automatic wait_ready();
        int t = 0;
        while (status[0] !== 1'b1 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        hv = 1'b0;
        wp = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(input logic [1:0] op, input int a, input int d, input logic h, input logic w);
        clear_logs();
        issue(op, a, d, h, w);
        wait_ready();
    endtask

    task automatic t_reset();
        chk("R1", "status after reset", int'(status), 4'b0001);
        chk("R1", "strobes after reset", int'({pgm, ers}), 0);
    endtask

    task automatic t_program();
        pgm_need = 1;
        run(2'b01, 40, 8'h3C, 0, 0);
        chk("R2", "word 40 value", int'(mem[40]), 8'h3C);
        chk("R2", "single strobe count", pgm_n, 1);
        chk("R2", "strobe address", pgm_log[0], 40);
        chk("R2", "status after program", int'(status), 4'b0001);
        pgm_need = 3;
        run(2'b01, 41, 8'h81, 0, 0);
        chk("R2", "retried strobe count", pgm_n, 3);
        chk("R2", "word 41 value", int'(mem[41]), 8'h81);
        pgm_need = 1;
    endtask

    task automatic t_pgm_limit();
        run(2'b01, 40, 8'hC3, 0, 0);
        chk("R3", "strobes before giving up", pgm_n, MAXP);
        chk("R3", "program error status", int'(status), 4'b0011);
    endtask

    task automatic t_sticky_clear();
        run(2'b01, 42, 8'h11, 0, 0);
        chk("R10", "error kept after good program", int'(status), 4'b0011);
        run(2'b11, 0, 0, 0, 0);
        chk("R10", "status after clear", int'(status), 4'b0001);
    endtask

    task automatic t_erase_param();
        int bad = 0;
        run(2'b01, 15, 8'hA5, 1, 0);
        chk("R8", "boot program with hv unlock", int'(mem[15]), 8'hA5);
        run(2'b01, 24, 8'h5A, 0, 0);
        run(2'b01, 18, 8'h77, 0, 0);
        ers_need[21] = 3;
        run(2'b10, 19, 0, 0, 0);
        chk("R4", "pre-program count", pgm_n, 8);
        for (int i = 0; i < 8; i++) if (pgm_log[i] != 16 + i) bad++;
        chk("R4", "pre-program order mismatches", bad, 0);
        chk("R5", "erase strobe count", ers_n, 3);
        chk("R5", "first erase address", ers_log[0], 16);
        chk("R5", "resume address 2nd", ers_log[1], 21);
        chk("R5", "resume address 3rd", ers_log[2], 21);
        bad = 0;
        for (int i = 16; i < 24; i++) if (mem[i] != 8'hFF) bad++;
        chk("R5", "words not erased", bad, 0);
        chk("R7", "word below block", int'(mem[15]), 8'hA5);
        chk("R7", "word above block", int'(mem[24]), 8'h5A);
        chk("R5", "status after erase", int'(status), 4'b0001);
        ers_need[21] = 1;
    endtask

    task automatic t_erase_main();
        run(2'b01, 63, 8'h12, 0, 0);
        run(2'b01, 96, 8'h34, 0, 0);
        run(2'b10, 70, 0, 0, 0);
        chk("R7", "main block pre-program count", pgm_n, 32);
        chk("R7", "main block first word", pgm_log[0], 64);
        chk("R7", "main block last word", pgm_log[31], 95);
        chk("R7", "main erase strobes", ers_n, 1);
        chk("R7", "word 63 untouched", int'(mem[63]), 8'h12);
        chk("R7", "word 96 untouched", int'(mem[96]), 8'h34);
    endtask

    task automatic t_erase_fail();
        ers_need[100] = 10;
        run(2'b10, 100, 0, 0, 0);
        chk("R6", "erase strobes before giving up", ers_n, MAXE);
        chk("R6", "erase error status", int'(status), 4'b0101);
        ers_need[100] = 1;
        run(2'b11, 0, 0, 0, 0);
    endtask

    task automatic t_protect();
        run(2'b01, 3, 8'h00, 0, 0);
        chk("R8", "locked program strobes", pgm_n, 0);
        chk("R8", "locked word unchanged", int'(mem[3]), 8'hFF);
        chk("R8", "protection status", int'(status), 4'b1001);
        run(2'b11, 0, 0, 0, 0);
        run(2'b10, 5, 0, 0, 0);
        chk("R8", "locked erase strobes", pgm_n + ers_n, 0);
        chk("R8", "protection status erase", int'(status), 4'b1001);
        run(2'b11, 0, 0, 0, 0);
        run(2'b01, 3, 8'h0F, 0, 1);
        chk("R8", "boot program with wp unlock", int'(mem[3]), 8'h0F);
        chk("R8", "status after unlocked program", int'(status), 4'b0001);
    endtask

    task automatic t_busy_ignore();
        clear_logs();
        issue(2'b10, 50, 0, 0, 0);
        repeat (5) @(negedge clk);
        chk("R9", "ready low while busy", int'(status[0]), 0);
        issue(2'b01, 24, 8'h00, 0, 0);
        wait_ready();
        chk("R9", "busy command ignored", int'(mem[24]), 8'h5A);
        chk("R9", "only block strobes", pgm_n, 32);
        chk("R9", "ready after erase", int'(status), 4'b0001);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            mem[i] = '1;
            ers_need[i] = 1;
        end
        clear_logs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_pgm_limit();
        t_sticky_clear();
        t_erase_param();
        t_erase_main();
        t_erase_fail();
        t_protect();
        t_busy_ignore();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule